// File: doc/BRIEF.md
# Column Burst Sequencer with Early Termination

This block drives the column side of read and write bursts in a synchronous graphics DRAM model. It watches the command pins each clock. When a read or write command is sampled, it loads the start column and then walks the column address through an aligned block of 1, 2, 4 or 8 columns, or through the whole 256-column page. The walk wraps inside that block. For each column it raises a column strobe. Each write column also raises a write enable. Each read column raises a read-valid strobe that appears a programmed CAS latency later.

A burst-stop command cuts a running burst short, but only when the burst was issued without auto precharge. A stopped write stops writing in the very cycle the stop is on the pins. A stopped read keeps delivering data for exactly one CAS latency of cycles. When the single-write option is set, every write touches one column, while reads still burst. A new read or write arriving mid-burst replaces the running burst. Bank activation, precharge timing and the cell array are handled elsewhere.

Top module: `burstSequencer`

## Requirements
- R1: A read (csN=0, rasN=1, casN=0, weN=1) or a write (csN=0, rasN=1, casN=0, weN=0, dsf=0) sampled at a rising edge makes colValid high with colAddr equal to startCol in the next cycle. With csN=1 the pins are ignored.
- R2: lenCode 0, 1, 2 and 3 select 1, 2, 4 and 8 columns, and codes 4 to 6 act as 1. Beat i carries address (startCol with the low log2(len) bits cleared) OR ((startCol+i) mod len).
- R3: colValid stays high for exactly len consecutive cycles after the command, then drops.
- R4: lenCode 7 selects a full page. The address counts up by one modulo 256 with no end until a stop or a new command arrives.
- R5: With singleWrite=1 a write burst issues exactly one column, while a read burst keeps its full length.
- R6: rdValid is high in cycle t exactly when a read column was issued in cycle t-casLat, for casLat 1, 2 and 3. Write columns never raise rdValid.
- R7: A stop (csN=0, rasN=1, casN=1, weN=0, dsf=0) during a burst without auto precharge drops colValid and wrEn in the cycle the stop is on the pins, and both stay low after it.
- R8: When a stop ends a read without auto precharge, rdValid stays high for exactly casLat cycles starting with the stop cycle, then drops.
- R9: A stop during a burst issued with autoPre=1 has no effect on any output.
- R10: A read or write command during a running burst lets the old burst issue its column in that cycle, then starts the new burst on the next cycle.
- R11: While rstN is low, colValid, wrEn and rdValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe pin |
| casN | input | 1 | Column strobe pin |
| weN | input | 1 | Write pin |
| dsf | input | 1 | Special-function pin, must be low for write and stop |
| startCol | input | COL_W | First column of a burst, sampled with the command |
| lenCode | input | 3 | Burst length selector, sampled with the command |
| autoPre | input | 1 | Burst issued with auto precharge, sampled with the command |
| singleWrite | input | 1 | Writes cover one column only |
| casLat | input | CL_W | Read latency in cycles (1 to MAX_CL), held steady while reads are in flight |
| colAddr | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A column is issued this cycle |
| wrEn | output | 1 | The issued column is written |
| rdValid | output | 1 | Read data for an earlier column is due this cycle |

## Verification
A command or stop is placed on the pins for one cycle and sampled at the rising edge inside it. The first column, with its colValid and wrEn, is due one cycle after the command cycle. The matching rdValid is due casLat cycles after each read column. The effect of a stop on colValid and wrEn shows in the stop cycle itself. The bench drives pins at the falling edge and samples the outputs a moment later in the same half cycle, so each cycle's check sees the state left by the previous edge combined with that cycle's pins. It sweeps direction, length code, start column, latency, single-write mode, auto precharge and the stop position, and computes every expected address and strobe from the beat index.

// File: rtl/burstSeqPkg.sv
package burstSeqPkg;
  // Strobes sent from the control half to the address datapath.
  typedef struct packed {
    logic load;     // capture a new start column and span
    logic step;     // advance to the next column of the running burst
    logic oneBeat;  // new burst is a single column regardless of length code
  } seqStrobe_t;

  localparam logic [2:0] LEN_FULL = 3'd7;
endpackage

// File: rtl/burstSeqPath.sv
module burstSeqPath
  import burstSeqPkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  output logic [COL_W-1:0] colAddr,
  output logic             lastBeat
);
  logic [COL_W-1:0] spanMask;
  logic [COL_W-1:0] remain;
  logic [COL_W-1:0] codeMask;
  logic [COL_W-1:0] nextCol;

  // Low-bit mask of the burst block; all ones selects the whole page.
  always_comb begin
    case (lenCode)
      3'd1:     codeMask = COL_W'(1);
      3'd2:     codeMask = COL_W'(3);
      3'd3:     codeMask = COL_W'(7);
      LEN_FULL: codeMask = '1;
      default:  codeMask = '0;
    endcase
  end

  assign nextCol  = (colAddr & ~spanMask) | ((colAddr + COL_W'(1)) & spanMask);
  assign lastBeat = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colAddr  <= '0;
      spanMask <= '0;
      remain   <= '0;
    end else if (strobe.load) begin
      colAddr  <= startCol;
      spanMask <= strobe.oneBeat ? '0 : codeMask;
      remain   <= strobe.oneBeat ? '0 : codeMask;
    end else if (strobe.step) begin
      colAddr  <= nextCol;
      remain   <= remain - COL_W'(1);
    end
  end
endmodule

// File: rtl/burstSeqCtrl.sv
module burstSeqCtrl
  import burstSeqPkg::*;
#(
  parameter int MAX_CL = 3,
  parameter int CL_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic            dsf,
  input  logic [2:0]      lenCode,
  input  logic            autoPre,
  input  logic            singleWrite,
  input  logic [CL_W-1:0] casLat,
  input  logic            lastBeat,
  output seqStrobe_t      strobe,
  output logic            colValid,
  output logic            wrEn,
  output logic            rdValid,
  output logic            autoPreHeld
);
  logic colCmd, rdCmd, wrCmd, loadCmd, stopCmd, stopHit;
  logic active, isRd, fullPage;
  logic oneBeat, rdIssue;
  logic [MAX_CL-1:0] rdPipe;
  logic [CL_W-1:0]   clIdx;

  assign colCmd  = !csN && rasN && !casN;
  assign rdCmd   = colCmd && weN;
  assign wrCmd   = colCmd && !weN && !dsf;
  assign loadCmd = rdCmd || wrCmd;
  assign stopCmd = !csN && rasN && casN && !weN && !dsf;
  assign stopHit = stopCmd && active && !autoPreHeld;
  assign oneBeat = wrCmd && singleWrite;

  assign colValid = active && !stopHit;
  assign wrEn     = colValid && !isRd;
  assign rdIssue  = colValid && isRd;

  assign strobe.load    = loadCmd;
  assign strobe.step    = active && !loadCmd;
  assign strobe.oneBeat = oneBeat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active      <= 1'b0;
      isRd        <= 1'b0;
      fullPage    <= 1'b0;
      autoPreHeld <= 1'b0;
    end else if (loadCmd) begin
      active      <= 1'b1;
      isRd        <= rdCmd;
      fullPage    <= (lenCode == LEN_FULL) && !oneBeat;
      autoPreHeld <= autoPre;
    end else if (stopHit) begin
      active      <= 1'b0;
    end else if (active && lastBeat && !fullPage) begin
      active      <= 1'b0;
    end
  end

  // Read strobe delay line, one stage per supported latency cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPipe <= '0;
    end else begin
      rdPipe[0] <= rdIssue;
      for (int i = 1; i < MAX_CL; i++) rdPipe[i] <= rdPipe[i-1];
    end
  end

  always_comb begin
    if (casLat == '0)                     clIdx = '0;
    else if (int'(casLat) > MAX_CL)       clIdx = CL_W'(MAX_CL - 1);
    else                                  clIdx = casLat - CL_W'(1);
  end

  assign rdValid = rdPipe[clIdx];
endmodule

// File: rtl/burstSequencer.sv
module burstSequencer
  import burstSeqPkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3,
  parameter int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             dsf,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             autoPre,
  input  logic             singleWrite,
  input  logic [CL_W-1:0]  casLat,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             wrEn,
  output logic             rdValid
);
  seqStrobe_t strobe;
  logic       lastBeat;
  logic       autoPreHeld;

  burstSeqCtrl #(.MAX_CL(MAX_CL), .CL_W(CL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .dsf(dsf), .lenCode(lenCode), .autoPre(autoPre),
    .singleWrite(singleWrite), .casLat(casLat), .lastBeat(lastBeat),
    .strobe(strobe), .colValid(colValid), .wrEn(wrEn),
    .rdValid(rdValid), .autoPreHeld(autoPreHeld)
  );

  burstSeqPath #(.COL_W(COL_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .lenCode(lenCode), .colAddr(colAddr), .lastBeat(lastBeat)
  );
endmodule

// File: rtl/burstSequencerChk.sv
module burstSequencerChk #(
  parameter int COL_W = 8,
  parameter int CL_W  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic             dsf,
  input logic             singleWrite,
  input logic [CL_W-1:0]  casLat,
  input logic [COL_W-1:0] colAddr,
  input logic             colValid,
  input logic             wrEn,
  input logic             rdValid,
  input logic             autoPreHeld
);
  logic loadPins, stopPins;
  assign loadPins = !csN && rasN && !casN && (weN || !dsf);
  assign stopPins = !csN && rasN && casN && !weN && !dsf;

  // R7: an honoured stop leaves no column on the following cycle.
  p_stop_cuts_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stopPins && !autoPreHeld) |=> !colValid);

  // R2: every step inside a burst flips the lowest address bit.
  p_addr_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && $past(colValid) && !$past(loadPins)) |-> (colAddr[0] != $past(colAddr[0])));

  // R5: a single-write column is never followed by another write without a new command.
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (singleWrite && wrEn && !loadPins) |=> !wrEn);

  // R6: read strobe lines up with a read column one or two cycles back.
  p_rd_lat1_r6: assert property (@(posedge clk) disable iff (!rstN)
    (casLat == CL_W'(1) && rdValid) |-> $past(colValid && !wrEn));

  p_rd_lat2_r6: assert property (@(posedge clk) disable iff (!rstN)
    (casLat == CL_W'(2) && rdValid) |-> $past(colValid && !wrEn, 2));
endmodule

bind burstSequencer burstSequencerChk #(.COL_W(COL_W), .CL_W(CL_W)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .dsf(dsf), .singleWrite(singleWrite), .casLat(casLat), .colAddr(colAddr),
  .colValid(colValid), .wrEn(wrEn), .rdValid(rdValid), .autoPreHeld(uCtrl.autoPreHeld)
);

// File: tb/tb_burstSequencer.sv
module tb_burstSequencer;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;
  localparam int BIG   = 1 << 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, dsf = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic autoPre = 1'b0, singleWrite = 1'b0;
  logic [1:0] casLat = 2'd1;
  logic [COL_W-1:0] colAddr;
  logic colValid, wrEn, rdValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burstSequencer dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .dsf(dsf), .startCol(startCol), .lenCode(lenCode), .autoPre(autoPre),
    .singleWrite(singleWrite), .casLat(casLat), .colAddr(colAddr),
    .colValid(colValid), .wrEn(wrEn), .rdValid(rdValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // kind: 0 nop, 1 read, 2 write, 3 stop
  task automatic setPins(input int kind);
    csN  = 1'b0;
    rasN = 1'b1;
    dsf  = 1'b0;
    casN = !(kind == 1 || kind == 2);
    weN  = !(kind == 2 || kind == 3);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    setPins(0);
    @(negedge clk);
    #1;
    chk("R11 colValid", int'(colValid), 0);
    chk("R11 wrEn", int'(wrEn), 0);
    chk("R11 rdValid", int'(rdValid), 0);
    rstN = 1'b1;
  endtask

  function automatic bit issued(input int i, input int leff, input bit stopEff, input int stopAt);
    if (i < 0 || i >= leff) return 1'b0;
    if (stopEff && i >= stopAt) return 1'b0;
    return 1'b1;
  endfunction

  task automatic runBurst(input bit wr, input int start, input int lc, input int cl,
                          input bit sw, input bit ap, input int stopAt);
    int len, leff, mask, lim, ncyc;
    bit oneBeat, fullRun, stopEff;
    string tAddr, tCol, tWr, tRd;
    oneBeat = wr && sw;
    len  = (lc == 7) ? 256 : ((lc <= 3) ? (1 << lc) : 1);
    fullRun = (lc == 7) && !oneBeat;
    leff = oneBeat ? 1 : (fullRun ? BIG : len);
    mask = oneBeat ? 0 : len - 1;
    stopEff = (stopAt >= 0) && !ap;
    lim  = stopEff ? ((stopAt < leff) ? stopAt : leff) : (fullRun ? 300 : leff);
    ncyc = lim + cl + 4;
    tAddr = fullRun ? "R4 addr" : "R2 addr";
    tCol  = stopEff ? "R7 colValid" : ((stopAt >= 0) ? "R9 colValid" : "R3 colValid");
    tWr   = oneBeat ? "R5 wrEn" : (stopEff ? "R7 wrEn" : "R3 wrEn");
    tRd   = (stopEff && !wr) ? "R8 rdValid" : ((stopAt >= 0) ? "R9 rdValid" : "R6 rdValid");
    resetDut();
    casLat = 2'(cl);
    singleWrite = sw;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (k == 0) begin
        setPins(wr ? 2 : 1);
        startCol = COL_W'(start);
        lenCode  = 3'(lc);
        autoPre  = ap;
      end else if (stopAt >= 0 && k == stopAt + 1) begin
        setPins(3);
      end else begin
        setPins(0);
        startCol = ~startCol;
        lenCode  = 3'd0;
        autoPre  = ~ap;
      end
      #1;
      begin
        bit expCol, expRd;
        int expAddr;
        expCol  = issued(k - 1, leff, stopEff, stopAt);
        expRd   = !wr && issued(k - 1 - cl, leff, stopEff, stopAt);
        expAddr = ((start & ~mask) | ((start + k - 1) & mask)) & 255;
        if (k == 1 && expCol) chk("R1 first column", int'(colValid), 1);
        chk(tCol, int'(colValid), int'(expCol));
        if (expCol) chk(tAddr, int'(colAddr), expAddr);
        chk(tWr, int'(wrEn), int'(expCol && wr));
        chk(tRd, int'(rdValid), int'(expRd));
      end
    end
  endtask

  initial begin
    int lcs[5] = '{0, 1, 2, 3, 7};
    int starts[3] = '{0, 5, 250};
    repeat (2) @(negedge clk);
    // R1: deselected read pins start nothing
    resetDut();
    casLat = 2'd1;
    @(negedge clk);
    setPins(1);
    csN = 1'b1;
    startCol = 8'h10;
    lenCode = 3'd3;
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      setPins(0);
      #1;
      chk("R1 deselect colValid", int'(colValid), 0);
      chk("R1 deselect rdValid", int'(rdValid), 0);
    end
    // reserved length code behaves as one column (R2)
    runBurst(1'b0, 9, 5, 1, 1'b0, 1'b0, -1);
    // main sweep
    for (int w = 0; w < 2; w++)
      for (int li = 0; li < 5; li++)
        for (int si = 0; si < 3; si++)
          for (int cl = 1; cl <= 3; cl++)
            for (int sw = 0; sw < 2; sw++) begin
              runBurst(w[0], starts[si], lcs[li], cl, sw[0], 1'b0, -1);
              if (lcs[li] >= 3) begin
                runBurst(w[0], starts[si], lcs[li], cl, sw[0], 1'b1, -1);
                runBurst(w[0], starts[si], lcs[li], cl, sw[0], 1'b0, 0);
                runBurst(w[0], starts[si], lcs[li], cl, sw[0], 1'b0, 2);
                runBurst(w[0], starts[si], lcs[li], cl, sw[0], 1'b1, 2);
              end
            end
    // R10: write replaces a running read, casLat 2
    resetDut();
    casLat = 2'd2;
    singleWrite = 1'b0;
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      if (k == 0) begin setPins(1); startCol = 8'h00; lenCode = 3'd3; autoPre = 1'b0; end
      else if (k == 3) begin setPins(2); startCol = 8'h40; lenCode = 3'd2; end
      else setPins(0);
      #1;
      if (k >= 1) begin
        bit expCol;
        int expAddr;
        expCol  = (k <= 7);
        expAddr = (k <= 3) ? k - 1 : 8'h40 + k - 4;
        chk("R10 colValid", int'(colValid), int'(expCol));
        if (expCol) chk("R10 addr", int'(colAddr), expAddr);
        chk("R10 wrEn", int'(wrEn), int'(k >= 4 && k <= 7));
        chk("R10 rdValid", int'(rdValid), int'(k >= 3 && k <= 5));
      end
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1 (run did not end)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule